// File: doc/BRIEF.md
# Multiplexed Parallel I/O Port

This block is a 16-pin parallel port in which every pin is set up on its own through a small register bus. A pin can be a general-purpose input, a general-purpose output, an output driven by an on-chip peripheral, or a pin that feeds one of two peripheral inputs, called primary and alternate. Three per-pin control bits choose the pin's role: a routing bit, a direction bit and an option bit. Peripheral inputs that are not connected to their pin get a defined level. That level is either a fixed constant chosen by parameter or the level of a companion signal taken from elsewhere in the chip.

Pins that are general-purpose inputs are first brought into the clock domain. Each one can then log any change or only a falling edge in a sticky event register. The event register is cleared by writing 1 to a bit. One interrupt line reports the OR of all pending events that are enabled in the mask register. Software writes an output latch and reads back the level seen at the pins. The register bus has a write strobe and a word address, and read data is registered.

Top module: `pio_mux_port`

## Requirements
- R1: After reset the direction, routing, option, trigger, mask, latch and event registers are all zero. Every pin_oe bit is 0 and irq is 0.
- R2: A write to the data register (address 0) updates the output latch even while the pin is an input. The latch value is not driven while the pin is an input, and it appears on pin_out once the pin is made an output.
- R3: A pin with routing bit 0 (address 2) and direction bit 1 (address 1) drives pin_out from its latch bit, with pin_oe set.
- R4: A read of address 0 returns the synchronized pin_in levels, not the latch.
- R5: A pin with routing bit 1 and direction bit 1 drives pin_out from per_out, with pin_oe set. A pin with direction bit 0 never has pin_oe set.
- R6: A pin with routing 1, direction 0 and option bit 0 (address 3) passes its synchronized level to per_pri_in. Every other pin gives per_pri_in its PRI_DEF bit.
- R7: A pin with routing 1, direction 0 and option bit 1 passes its synchronized level to per_alt_in.
- R8: When per_alt_in is not routed, it takes ext_lvl where the ALT_EXT mask bit is set and the ALT_DEF bit otherwise.
- R9: For a general-purpose input whose trigger bit (address 4) is 0, any change in level sets its event bit (address 6).
- R10: For a general-purpose input whose trigger bit is 1, only a high-to-low transition sets its event bit.
- R11: Level changes on a pin that is not a general-purpose input never set its event bit.
- R12: Writing 1 to an event bit clears it. irq is the OR of the event bits ANDed with the mask bits (address 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for bus_addr |
| pin_in | input | 16 | Levels sampled at the pins |
| pin_out | output | 16 | Values driven to the pins |
| pin_oe | output | 16 | Pin output enables |
| per_out | input | 16 | Peripheral output values for each pin |
| per_pri_in | output | 16 | Primary peripheral inputs |
| per_alt_in | output | 16 | Alternate peripheral inputs |
| ext_lvl | input | 16 | Companion levels used as alternate defaults |
| irq | output | 1 | Masked port interrupt |

## Verification
The hardest cases to reach are the ones that depend on the pin's role as well as on its edge: a falling edge on a pin in falling-only mode, and a toggle on a pin that is currently an output, where nothing may happen. To reach them, the stimulus first reconfigures the pins through the bus. It then clears every event left over from that setup and only then drives pin_in. It then checks the event register and irq after the synchronizer and detector delay. Each routing choice is also checked by moving pin_in and ext_lvl and watching both peripheral input vectors change or stay at their defaults.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    RA_DATA = 3'd0,
    RA_DIR  = 3'd1,
    RA_ROUTE = 3'd2,
    RA_OPT  = 3'd3,
    RA_TRIG = 3'd4,
    RA_MASK = 3'd5,
    RA_EVT  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    meta <= d;
    q    <= meta;
  end
endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux #(
  parameter bit PRI_D  = 1'b0,
  parameter bit ALT_D  = 1'b0,
  parameter bit ALT_X  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic route,
  input  logic dir,
  input  logic opt,
  input  logic latch,
  input  logic per_o,
  input  logic lvl,
  input  logic ext,
  output logic gpi_en,
  output logic oe_q,
  output logic out_q,
  output logic pri_q,
  output logic alt_q
);
  logic gpo, pdrv, pri_sel, alt_sel;
  logic oe_d, out_d, pri_d, alt_d, alt_fill;

  always_comb begin
    gpo      = !route && dir;
    pdrv     = route && dir;
    pri_sel  = route && !dir && !opt;
    alt_sel  = route && !dir && opt;
    gpi_en   = !route && !dir;
    oe_d     = gpo || pdrv;
    out_d    = pdrv ? per_o : (gpo ? latch : 1'b0);
    alt_fill = ALT_X ? ext : ALT_D;
    pri_d    = pri_sel ? lvl : PRI_D;
    alt_d    = alt_sel ? lvl : alt_fill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
      pri_q <= PRI_D;
      alt_q <= ALT_D;
    end else begin
      oe_q  <= oe_d;
      out_q <= out_d;
      pri_q <= pri_d;
      alt_q <= alt_d;
    end
  end

  // R5: an enabled output always follows a cycle with direction set
  a_r5_oe_needs_dir: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> $past(dir));
endmodule

// File: rtl/pio_evt.sv
module pio_evt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] gpi_en,
  input  logic [W-1:0] trig_fall,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] evt,
  output logic         irq
);
  logic [W-1:0] prev;
  logic [W-1:0] hit;

  always_ff @(posedge clk) prev <= lvl;

  always_comb begin
    for (int i = 0; i < W; i++)
      hit[i] = gpi_en[i] && (trig_fall[i] ? (prev[i] && !lvl[i]) : (prev[i] != lvl[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt <= '0;
      irq <= 1'b0;
    end else begin
      evt <= (evt & ~clr) | hit;
      irq <= |(evt & mask);
    end
  end

  a_r12_mask_off: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);

  for (genvar g = 0; g < W; g++) begin : g_chk
    a_r11_gpi_only: assert property (@(posedge clk) disable iff (rst)
      $rose(evt[g]) |-> $past(gpi_en[g]));
    a_r10_fall_only: assert property (@(posedge clk) disable iff (rst)
      ($rose(evt[g]) && $past(trig_fall[g])) |-> (!$past(lvl[g]) && $past(lvl[g], 2)));
  end
endmodule

// File: rtl/pio_mux_port.sv
module pio_mux_port #(
  parameter int              NPIN    = 16,
  parameter logic [NPIN-1:0] PRI_DEF = 16'h00F0,
  parameter logic [NPIN-1:0] ALT_DEF = 16'h0F00,
  parameter logic [NPIN-1:0] ALT_EXT = 16'hF000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic [NPIN-1:0] per_out,
  output logic [NPIN-1:0] per_pri_in,
  output logic [NPIN-1:0] per_alt_in,
  input  logic [NPIN-1:0] ext_lvl,
  output logic            irq
);
  import pio_pkg::*;

  logic [NPIN-1:0] latch_q, dir_q, route_q, opt_q, trig_q, mask_q;
  logic [NPIN-1:0] lvl, gpi_en, evt, clr;
  reg_addr_e       ra;

  assign ra  = reg_addr_e'(bus_addr);
  assign clr = (bus_we && ra == RA_EVT) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      route_q <= '0;
      opt_q   <= '0;
      trig_q  <= '0;
      mask_q  <= '0;
    end else if (bus_we) begin
      case (ra)
        RA_DATA:  latch_q <= bus_wdata;
        RA_DIR:   dir_q   <= bus_wdata;
        RA_ROUTE: route_q <= bus_wdata;
        RA_OPT:   opt_q   <= bus_wdata;
        RA_TRIG:  trig_q  <= bus_wdata;
        RA_MASK:  mask_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (ra)
        RA_DATA:  bus_rdata <= lvl;
        RA_DIR:   bus_rdata <= dir_q;
        RA_ROUTE: bus_rdata <= route_q;
        RA_OPT:   bus_rdata <= opt_q;
        RA_TRIG:  bus_rdata <= trig_q;
        RA_MASK:  bus_rdata <= mask_q;
        RA_EVT:   bus_rdata <= evt;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  pio_sync #(.W(NPIN)) u_sync (.clk(clk), .d(pin_in), .q(lvl));

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    pio_pin_mux #(
      .PRI_D(PRI_DEF[g]), .ALT_D(ALT_DEF[g]), .ALT_X(ALT_EXT[g])
    ) u_mux (
      .clk(clk), .rst(rst),
      .route(route_q[g]), .dir(dir_q[g]), .opt(opt_q[g]),
      .latch(latch_q[g]), .per_o(per_out[g]), .lvl(lvl[g]), .ext(ext_lvl[g]),
      .gpi_en(gpi_en[g]), .oe_q(pin_oe[g]), .out_q(pin_out[g]),
      .pri_q(per_pri_in[g]), .alt_q(per_alt_in[g])
    );
  end

  pio_evt #(.W(NPIN)) u_evt (
    .clk(clk), .rst(rst), .lvl(lvl), .gpi_en(gpi_en), .trig_fall(trig_q),
    .clr(clr), .mask(mask_q), .evt(evt), .irq(irq)
  );

  // R1: reset leaves every pin undriven and the interrupt low
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && !irq));
endmodule

// File: tb/pio_mux_port_tb.sv
`timescale 1ns/1ps
module pio_mux_port_tb;
  localparam int N = 16;
  localparam logic [N-1:0] PD = 16'h00F0, AD = 16'h0F00, AX = 16'hF000;

  logic clk = 0, rst = 1, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [N-1:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
  logic [N-1:0] per_out = 0, per_pri_in, per_alt_in, ext_lvl = 16'hA000;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pio_mux_port #(.NPIN(N), .PRI_DEF(PD), .ALT_DEF(AD), .ALT_EXT(AX)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .per_out(per_out),
    .per_pri_in(per_pri_in), .per_alt_in(per_alt_in), .ext_lvl(ext_lvl), .irq(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    settle();
    chk("R1 oe", pin_oe, '0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rd(3'd1, v); chk("R1 dir", v, '0);
    rd(3'd5, v); chk("R1 mask", v, '0);
    chk("R6 pri default", per_pri_in, PD);
    chk("R8 alt default", per_alt_in, (AD & ~AX) | (ext_lvl & AX));
  endtask

  task automatic t_latch();
    wr(3'd0, 16'h1234); settle();
    chk("R2 latch not driven", pin_oe, '0);
    wr(3'd1, 16'h00FF); settle();
    chk("R3 oe", pin_oe, 16'h00FF);
    chk("R2 R3 out", pin_out, 16'h0034);
  endtask

  task automatic t_readback();
    logic [N-1:0] v;
    pin_in = 16'h5A5A; settle();
    rd(3'd0, v); chk("R4 read pins", v, 16'h5A5A);
  endtask

  task automatic t_periph();
    wr(3'd2, 16'hF000); wr(3'd1, 16'h30FF); wr(3'd3, 16'h8000);
    per_out = 16'h1000; settle();
    chk("R5 oe", pin_oe, 16'h30FF);
    chk("R5 out", pin_out, 16'h1034);
    chk("R6 pri", per_pri_in, 16'h40F0);
    chk("R7 alt", per_alt_in, 16'h2F00);
    pin_in = 16'h9A5A; settle();
    chk("R6 pri follow", per_pri_in, 16'h00F0);
    chk("R7 alt follow", per_alt_in, 16'hAF00);
    ext_lvl = 16'h5000; settle();
    chk("R8 ext default", per_alt_in, 16'hDF00);
    wr(3'd2, 16'h0000); wr(3'd3, 16'h0000); wr(3'd1, 16'h0001);
  endtask

  task automatic t_any_edge();
    logic [N-1:0] v;
    wr(3'd4, 16'h0000); wr(3'd5, 16'hFFFF);
    pin_in = 16'h0000; settle();
    wr(3'd6, 16'hFFFF); settle();
    chk("R12 irq clear", {15'd0, irq}, 16'd0);
    pin_in = 16'h0010; settle();
    rd(3'd6, v); chk("R9 rise", v, 16'h0010);
    chk("R12 irq set", {15'd0, irq}, 16'd1);
    wr(3'd6, 16'h0010); settle();
    rd(3'd6, v); chk("R12 w1c", v, 16'h0000);
    chk("R12 irq drop", {15'd0, irq}, 16'd0);
    pin_in = 16'h0000; settle();
    rd(3'd6, v); chk("R9 fall", v, 16'h0010);
    wr(3'd6, 16'hFFFF); settle();
  endtask

  task automatic t_fall();
    logic [N-1:0] v;
    wr(3'd4, 16'h0020);
    pin_in = 16'h0020; settle();
    rd(3'd6, v); chk("R10 rise ignored", v, 16'h0000);
    pin_in = 16'h0000; settle();
    rd(3'd6, v); chk("R10 fall", v, 16'h0020);
    wr(3'd6, 16'hFFFF); settle();
  endtask

  task automatic t_out_noevt();
    logic [N-1:0] v;
    wr(3'd4, 16'h0001);
    pin_in = 16'h0001; settle();
    pin_in = 16'h0000; settle();
    rd(3'd6, v); chk("R11 no event", v, 16'h0000);
    chk("R11 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_mask();
    logic [N-1:0] v;
    wr(3'd5, 16'h0000); wr(3'd4, 16'h0000);
    pin_in = 16'h0010; settle();
    rd(3'd6, v); chk("R12 pending", v, 16'h0010);
    chk("R12 masked", {15'd0, irq}, 16'd0);
    wr(3'd5, 16'h0010); settle();
    chk("R12 unmasked", {15'd0, irq}, 16'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_latch();
    t_readback();
    t_periph();
    t_any_edge();
    t_fall();
    t_out_noevt();
    t_mask();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule